// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for each beat of a short burst. When an access begins, it registers the whole incoming address. The low `BEAT_W` bits become the starting beat, and the bits above them become a fixed upper part. Each advance request moves the sequencer on by one beat. The low bits then take the next value in the selected order. They wrap inside their own block and never carry into the upper part.

Two strobes can open an access:

- The controller strobe is always honoured.
- The processor strobe is honoured only while the chip select is active.

A static mode input picks the beat order:

- **Interleaved order:** beat k gives the start XOR k.
- **Linear order:** beat k gives the start plus k, modulo the block size.

The registered state drives the output, so a cycle in which nothing is requested leaves the address unchanged.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released with no request, `addr_out` is all zeros.
- R2: `ctrl_strobe` high at a rising edge makes `addr_out` equal to the `addr_in` sampled at that edge, from the next cycle on, whatever `chip_sel` is.
- R3: `proc_strobe` high with `chip_sel` high at a rising edge loads `addr_in` the same way as R2.
- R4: `proc_strobe` high with `chip_sel` low and `ctrl_strobe` low is ignored, and `addr_out` keeps its previous value.
- R5: With `seq_linear` = 0 (interleaved), after k advances since a load, the low `BEAT_W` bits of `addr_out` equal the start XOR (k mod 2^BEAT_W). For example, start 2 gives 2, 3, 0, 1.
- R6: With `seq_linear` = 1 (linear), after k advances, the low bits equal (start + k) mod 2^BEAT_W. For example, start 1 gives 1, 2, 3, 0.
- R7: The upper bits of `addr_out` (above the low `BEAT_W` bits) change only at a load and never take a carry from the low bits.
- R8: When a strobe that is honoured and `adv` are both high at the same edge, the load wins and the new burst starts at beat 0.
- R9: An edge with no honoured strobe and `adv` low leaves `addr_out` unchanged, provided `seq_linear` is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seq_linear | input | 1 | Beat order: 1 linear, 0 interleaved; held static during a burst |
| chip_sel | input | 1 | Active-high select that qualifies the processor strobe |
| proc_strobe | input | 1 | Processor access start, gated by `chip_sel` |
| ctrl_strobe | input | 1 | Controller access start, always honoured |
| adv | input | 1 | Advance to the next beat |
| addr_in | input | ADDR_W | Address captured at a strobe |
| addr_out | output | ADDR_W | Current beat address |

## Verification
The bench builds the block with `ADDR_W` = 10 and `BEAT_W` = 2. The eight-bit upper part is then wide enough to carry distinct patterns, including all ones, so any carry out of the low bits or a stray reload would show. With the default four-beat block, every start value can be run in both orders past the wrap point, and a hold cycle can be placed in the middle of each burst. Directed cases cover a gated processor strobe, a strobe that coincides with an advance, and a reload with the low bits at their largest value.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_CTRL = 2'd1,
    SRC_PROC = 2'd2
  } load_src_e;
endpackage

// File: rtl/burst_start_arb.sv
module burst_start_arb
  import burst_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      chip_sel,
  input  logic      proc_strobe,
  input  logic      ctrl_strobe,
  input  logic      adv,
  output logic      load_evt,
  output logic      step_evt,
  output load_src_e load_src
);
  always_comb begin
    if (ctrl_strobe)                  load_src = SRC_CTRL;
    else if (proc_strobe && chip_sel) load_src = SRC_PROC;
    else                              load_src = SRC_NONE;
  end

  assign load_evt = (load_src != SRC_NONE);
  assign step_evt = adv && !load_evt;

  // R4: a processor strobe without chip select starts nothing
  a_r4_proc_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_strobe && !chip_sel && !ctrl_strobe) |-> !load_evt);
  // R8: a load and a step never happen at the same edge
  a_r8_load_over_step: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_evt && step_evt));
  // R2: the controller strobe always loads
  a_r2_ctrl_loads: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_strobe |-> load_evt);
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_evt,
  input  logic                     step_evt,
  input  logic [ADDR_W-1:0]        addr_in,
  output logic [ADDR_W-BEAT_W-1:0] upper_q,
  output logic [BEAT_W-1:0]        start_q,
  output logic [BEAT_W-1:0]        beat_q
);
  localparam int UPPER_W = ADDR_W - BEAT_W;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upper_q <= '0;
      start_q <= '0;
      beat_q  <= '0;
    end else if (load_evt) begin
      upper_q <= addr_in[ADDR_W-1:BEAT_W];
      start_q <= addr_in[BEAT_W-1:0];
      beat_q  <= '0;
    end else if (step_evt) begin
      beat_q  <= beat_q + 1'b1;
    end
  end

  // R7: upper part and start move only on a load
  a_r7_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> ($stable(upper_q) && $stable(start_q)));
  // R9: an idle edge freezes the beat index
  a_r9_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && !step_evt) |=> $stable(beat_q));
  // R5/R6: each step moves the beat index by exactly one, wrapping
  a_r5_beat_step: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> beat_q == BEAT_W'($past(beat_q) + 1'b1));
endmodule

// File: rtl/burst_beat_map.sv
module burst_beat_map #(
  parameter int BEAT_W = 2
) (
  input  logic              seq_linear,
  input  logic [BEAT_W-1:0] start,
  input  logic [BEAT_W-1:0] beat,
  output logic [BEAT_W-1:0] low
);
  function automatic logic [BEAT_W-1:0] order_interleave(
    input logic [BEAT_W-1:0] s, input logic [BEAT_W-1:0] k);
    return s ^ k;
  endfunction

  function automatic logic [BEAT_W-1:0] order_linear(
    input logic [BEAT_W-1:0] s, input logic [BEAT_W-1:0] k);
    return s + k;
  endfunction

  assign low = seq_linear ? order_linear(start, beat)
                          : order_interleave(start, beat);

  always_comb begin
    // R5/R6: beat zero always reproduces the start value in either order
    if (beat == '0) a_r5_r6_beat0: assert (low == start);
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_linear,
  input  logic              chip_sel,
  input  logic              proc_strobe,
  input  logic              ctrl_strobe,
  input  logic              adv,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);
  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic               load_evt;
  logic               step_evt;
  load_src_e          load_src;
  logic [UPPER_W-1:0] upper_q;
  logic [BEAT_W-1:0]  start_q;
  logic [BEAT_W-1:0]  beat_q;
  logic [BEAT_W-1:0]  low_bits;

  burst_start_arb u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .chip_sel    (chip_sel),
    .proc_strobe (proc_strobe),
    .ctrl_strobe (ctrl_strobe),
    .adv         (adv),
    .load_evt    (load_evt),
    .step_evt    (step_evt),
    .load_src    (load_src)
  );

  burst_beat_ctr #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_evt (load_evt),
    .step_evt (step_evt),
    .addr_in  (addr_in),
    .upper_q  (upper_q),
    .start_q  (start_q),
    .beat_q   (beat_q)
  );

  burst_beat_map #(.BEAT_W(BEAT_W)) u_map (
    .seq_linear (seq_linear),
    .start      (start_q),
    .beat       (beat_q),
    .low        (low_bits)
  );

  assign addr_out = {upper_q, low_bits};

  // R2/R3: a load presents the captured address on the next cycle
  a_r3_load_visible: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> addr_out == $past(addr_in));
  // R6: a linear step adds one to the low bits
  a_r6_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && seq_linear) |=> (seq_linear == 1'b0) ||
      addr_out[BEAT_W-1:0] == BEAT_W'($past(addr_out[BEAT_W-1:0]) + 1'b1));
  // R9: nothing requested and mode held keeps the address
  a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && !adv) |=> ($stable(addr_out) || !$stable(seq_linear)));
  // R1: reset state
  a_r1_reset_zero: assert property (@(posedge clk)
    !rst_n |=> addr_out == '0);
endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb_top;
  localparam int ADDR_W = 10;
  localparam int BEAT_W = 2;
  localparam int CLK_PERIOD = 10;
  localparam int NBEATS = 6;

  // {seq_linear, start, expected low bits beat0..beat5 (beat0 in MSBs)}
  localparam logic [14:0] VEC [8] = '{
    {1'b0, 2'd0, 12'b00_01_10_11_00_01},
    {1'b0, 2'd1, 12'b01_00_11_10_01_00},
    {1'b0, 2'd2, 12'b10_11_00_01_10_11},
    {1'b0, 2'd3, 12'b11_10_01_00_11_10},
    {1'b1, 2'd0, 12'b00_01_10_11_00_01},
    {1'b1, 2'd1, 12'b01_10_11_00_01_10},
    {1'b1, 2'd2, 12'b10_11_00_01_10_11},
    {1'b1, 2'd3, 12'b11_00_01_10_11_00}
  };

  logic clk = 1'b0;
  logic rst_n, seq_linear, chip_sel, proc_strobe, ctrl_strobe, adv;
  logic [ADDR_W-1:0] addr_in, addr_out;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .seq_linear(seq_linear), .chip_sel(chip_sel),
    .proc_strobe(proc_strobe), .ctrl_strobe(ctrl_strobe), .adv(adv),
    .addr_in(addr_in), .addr_out(addr_out)
  );

  task automatic check(input string req, input logic [ADDR_W-1:0] exp);
    checks++;
    if (addr_out !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, addr_out, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, come back to a falling edge
  task automatic cyc(input logic c, input logic p, input logic cs,
                     input logic a, input logic [ADDR_W-1:0] ain);
    ctrl_strobe = c; proc_strobe = p; chip_sel = cs; adv = a; addr_in = ain;
    @(posedge clk);
    @(negedge clk);
    ctrl_strobe = 1'b0; proc_strobe = 1'b0; adv = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [ADDR_W-1:0] held;
    rst_n = 1'b0; seq_linear = 1'b0; chip_sel = 1'b0;
    proc_strobe = 1'b0; ctrl_strobe = 1'b0; adv = 1'b0; addr_in = '1;
    @(negedge clk); @(negedge clk);
    check("R1 in reset", '0);
    rst_n = 1'b1;
    cyc(1'b0, 1'b0, 1'b0, 1'b0, '1);
    check("R1 after release", '0);

    // table walk: load through the controller strobe, chip_sel low
    for (int v = 0; v < 8; v++) begin
      logic [7:0] up;
      logic [ADDR_W-1:0] base;
      up = 8'hA5 ^ 8'(v * 37);
      seq_linear = VEC[v][14];
      base = {up, VEC[v][13:12]};
      cyc(1'b1, 1'b0, 1'b0, 1'b0, base);
      check("R2 ctrl load", base);
      for (int k = 1; k < NBEATS; k++) begin
        cyc(1'b0, 1'b0, 1'b0, 1'b1, '0);
        check(VEC[v][14] ? "R6 linear beat / R7" : "R5 interleaved beat / R7",
              {up, VEC[v][11 - 2*k -: 2]});
        if (k == 2) begin
          cyc(1'b0, 1'b0, 1'b0, 1'b0, '1);
          check("R9 hold mid-burst", {up, VEC[v][11 - 2*k -: 2]});
        end
      end
    end

    // R4: gated processor strobe, address must not move
    seq_linear = 1'b1;
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 10'h155);
    held = addr_out;
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 10'h2AA);
    check("R4 proc strobe ignored", held);

    // R3: processor strobe with chip select
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 10'h2AA);
    check("R3 proc load", 10'h2AA);

    // R8: strobe and adv together start at beat zero
    cyc(1'b0, 1'b0, 1'b0, 1'b1, '0);
    check("R6 step before R8", 10'h2AB);
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 10'h0C1);
    check("R8 load beats adv", 10'h0C1);

    // R7: upper all ones, low at 3, linear step wraps without carry
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 10'h3FF);
    check("R2 load all ones", 10'h3FF);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, '0);
    check("R7 no carry on wrap", 10'h3FC);

    // R1: reset mid-burst clears the address
    rst_n = 1'b0;
    cyc(1'b0, 1'b0, 1'b0, 1'b1, '0);
    check("R1 reset mid-burst", '0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule